// File: doc/BRIEF.md
# Transmit/Receive Byte Queue Pair with Fill Watermarks

This block holds the two byte queues that sit between a two-wire serial bus controller's register interface and its bus engine. Software writes the transmit queue. Each transmit entry carries a data byte and two flag bits above it. The bus engine drains the transmit queue and fills the receive queue. Software then empties the receive queue one entry per data read.

The block reports how full each queue is in a zero-based form: a queue holding N entries reads back N-1, and an empty queue reads back zero. Software uses the empty status flags to tell an empty queue apart from one that holds a single entry. A programmable zero-based threshold raises a receive-level condition. A transmit-half-empty condition signals when software should refill. A held flush input empties the transmit queue.

All four data paths use valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. A queue lowers its ready while it is full, or for the transmit queue while the flush is held. It lowers its valid while it is empty or flushed. A source may hold valid high through back-pressure. Valid must not depend on ready.

Top module: `twowire_fifo_pair`

## Requirements
- R1: Each queue stores 16 entries. The 16th accepted push raises the full flag, and the input ready of that queue goes low.
- R2: The occupancy outputs give the stored entry count minus one. They read 0 both for an empty queue and for a queue holding one entry.
- R3: The status nibble puts transmit full in bit 0, receive full in bit 1, receive empty in bit 2 and transmit empty in bit 3. After reset it reads 4'b1100.
- R4: The receive-level condition is high exactly when the receive queue holds at least rx_thresh+1 entries.
- R5: While tx_flush is high, the transmit queue discards its contents, reports empty with occupancy 0, and accepts no push. After tx_flush is released the queue stays empty until a push arrives.
- R6: The transmit-half-empty condition is high when the transmit queue holds 8 entries or fewer, and low when it holds 9 or more.
- R7: Each receive pop removes exactly one entry, and the bytes leave in the order they arrived.
- R8: A push into a full queue changes neither its occupancy nor its contents. A pop request on an empty queue leaves it empty.
- R9: Transmit entries are 10 bits wide. They reach the bus-engine side unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_flush | input | 1 | Holds the transmit queue empty while high |
| rx_thresh | input | 4 | Zero-based receive threshold |
| tx_in_valid | input | 1 | Register-side transmit push valid |
| tx_in_ready | output | 1 | Transmit queue can accept a push |
| tx_in_data | input | 10 | Transmit entry: flag bits 9:8, byte 7:0 |
| tx_out_valid | output | 1 | Transmit entry available to bus engine |
| tx_out_ready | input | 1 | Bus engine takes the transmit entry |
| tx_out_data | output | 10 | Oldest transmit entry |
| rx_in_valid | input | 1 | Bus-engine receive push valid |
| rx_in_ready | output | 1 | Receive queue can accept a push |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Receive byte available to software |
| rx_out_ready | input | 1 | Register read pops the receive byte |
| rx_out_data | output | 8 | Oldest received byte |
| tx_level | output | 4 | Transmit occupancy minus one (0 when empty) |
| rx_level | output | 4 | Receive occupancy minus one (0 when empty) |
| status_nib | output | 4 | Full/empty flags as listed in R3 |
| irq_rx_level | output | 1 | Receive-level condition |
| irq_tx_half | output | 1 | Transmit-half-empty condition |

## Verification
Counts, flags and conditions are decoded without further registers from the count registers. They therefore change one clock edge after the accepting edge. The head data outputs are shown ahead and are valid in the same cycle as their valid. The bench drives each transfer from a falling edge and lets one rising edge pass. It then samples at the next falling edge, so every level, flag and condition is read one edge after its cause. Pop data is compared just before the edge that consumes it.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int unsigned QDEPTH_DEF = 16;
  localparam int unsigned TXW_DEF    = 10;
  localparam int unsigned RXW_DEF    = 8;
endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push, pop;

  assign in_ready  = !clr && (count != CW'(DEPTH));
  assign out_valid = !clr && (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/occ_view.sv
module occ_view #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [CW-1:0] dec;
  assign dec   = count - CW'(1);
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign level = empty ? '0 : dec[LW-1:0];
endmodule

// File: rtl/twowire_fifo_pair.sv
module twowire_fifo_pair
  import fifo_pair_pkg::*;
#(
  parameter int unsigned DEPTH = QDEPTH_DEF,
  parameter int unsigned TXW   = TXW_DEF,
  parameter int unsigned RXW   = RXW_DEF,
  localparam int unsigned LW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_flush,
  input  logic [LW-1:0]  rx_thresh,
  input  logic           tx_in_valid,
  output logic           tx_in_ready,
  input  logic [TXW-1:0] tx_in_data,
  output logic           tx_out_valid,
  input  logic           tx_out_ready,
  output logic [TXW-1:0] tx_out_data,
  input  logic           rx_in_valid,
  output logic           rx_in_ready,
  input  logic [RXW-1:0] rx_in_data,
  output logic           rx_out_valid,
  input  logic           rx_out_ready,
  output logic [RXW-1:0] rx_out_data,
  output logic [LW-1:0]  tx_level,
  output logic [LW-1:0]  rx_level,
  output logic [3:0]     status_nib,
  output logic           irq_rx_level,
  output logic           irq_tx_half
);
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;

  byte_queue #(.DEPTH(DEPTH), .W(TXW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_flush),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .count(tx_cnt));

  byte_queue #(.DEPTH(DEPTH), .W(RXW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(1'b0),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .count(rx_cnt));

  occ_view #(.DEPTH(DEPTH)) u_txv (
    .count(tx_cnt), .level(tx_level), .full(tx_full), .empty(tx_empty));

  occ_view #(.DEPTH(DEPTH)) u_rxv (
    .count(rx_cnt), .level(rx_level), .full(rx_full), .empty(rx_empty));

  assign status_nib   = {tx_empty, rx_empty, rx_full, tx_full};
  assign irq_rx_level = (rx_cnt > CW'(rx_thresh));
  assign irq_tx_half  = (tx_cnt <= CW'(DEPTH / 2));
endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_flush,
  input logic          tx_in_ready,
  input logic          rx_in_valid,
  input logic          rx_in_ready,
  input logic          rx_out_valid,
  input logic          rx_out_ready,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic [3:0]    status_nib,
  input logic          irq_rx_level,
  input logic [CW-1:0] rx_cnt
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (status_nib[3] && tx_level == '0)); // R5
  AST_FLUSH_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |-> !tx_in_ready); // R5
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_nib[2] |-> (rx_level == '0)); // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_nib[0] && status_nib[3]) && !(status_nib[1] && status_nib[2])); // R3
  AST_EMPTY_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    status_nib[2] |-> !irq_rx_level); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (status_nib[1] && !(rx_out_valid && rx_out_ready)) |=> $stable(rx_cnt)); // R8
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && rx_out_ready && !(rx_in_valid && rx_in_ready))
      |=> (rx_cnt == $past(rx_cnt) - CW'(1))); // R7
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    status_nib[1] |-> !rx_in_ready); // R1
endmodule

bind twowire_fifo_pair fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_flush(tx_flush), .tx_in_ready(tx_in_ready),
  .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
  .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
  .tx_level(tx_level), .rx_level(rx_level), .status_nib(status_nib),
  .irq_rx_level(irq_rx_level), .rx_cnt(rx_cnt));

// File: tb/twowire_fifo_pair_tb.sv
module twowire_fifo_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // vector: {op, data, exp tx_level, exp rx_level, exp status, exp rx hit}
  // op: 0 push tx, 1 pop tx, 2 push rx, 3 pop rx
  localparam logic [24:0] VEC [NVEC] = '{
    {2'd0, 10'h2A5, 4'd0, 4'd0, 4'b0100, 1'b0},
    {2'd0, 10'h1C3, 4'd1, 4'd0, 4'b0100, 1'b0},
    {2'd2, 10'h011, 4'd1, 4'd0, 4'b0000, 1'b0},
    {2'd2, 10'h022, 4'd1, 4'd1, 4'b0000, 1'b0},
    {2'd2, 10'h033, 4'd1, 4'd2, 4'b0000, 1'b1},
    {2'd3, 10'h011, 4'd1, 4'd1, 4'b0000, 1'b0},
    {2'd1, 10'h2A5, 4'd0, 4'd1, 4'b0000, 1'b0},
    {2'd1, 10'h1C3, 4'd0, 4'd1, 4'b1000, 1'b0},
    {2'd3, 10'h022, 4'd0, 4'd0, 4'b1000, 1'b0},
    {2'd3, 10'h033, 4'd0, 4'd0, 4'b1100, 1'b0}
  };

  logic clk = 0, rst_n = 0, tx_flush = 0;
  logic [3:0] rx_thresh = 4'd2;
  logic tx_in_valid = 0, tx_out_ready = 0, rx_in_valid = 0, rx_out_ready = 0;
  logic [9:0] tx_in_data = '0;
  logic [7:0] rx_in_data = '0;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [9:0] tx_out_data;
  logic [7:0] rx_out_data;
  logic [3:0] tx_level, rx_level, status_nib;
  logic irq_rx_level, irq_tx_half;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  twowire_fifo_pair u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [9:0] d);
    case (op)
      2'd0: begin tx_in_valid = 1; tx_in_data = d; end
      2'd1: tx_out_ready = 1;
      2'd2: begin rx_in_valid = 1; rx_in_data = d[7:0]; end
      default: rx_out_ready = 1;
    endcase
    @(posedge clk);
    @(negedge clk);
    tx_in_valid = 0; tx_out_ready = 0; rx_in_valid = 0; rx_out_ready = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset status", status_nib, 4'b1100);
    chk("R2 reset tx level", tx_level, 0);
    chk("R2 reset rx level", rx_level, 0);

    // table walk, threshold 2
    for (int i = 0; i < NVEC; i++) begin
      logic [24:0] v;
      v = VEC[i];
      if (v[24:23] == 2'd1) chk("R9 tx order", tx_out_data, v[22:13]);
      if (v[24:23] == 2'd3) chk("R7 rx order", rx_out_data, v[20:13]);
      step(v[24:23], v[22:13]);
      chk("R2 tx level", tx_level, v[12:9]);
      chk("R2 rx level", rx_level, v[8:5]);
      chk("R3 status", status_nib, v[4:1]);
      chk("R4 rx hit", irq_rx_level, v[0]);
    end

    // fill receive queue to depth
    for (int i = 0; i < 16; i++) step(2'd2, 10'(8'h40 + i));
    chk("R1 rx full level", rx_level, 15);
    chk("R1 rx full flag", status_nib[1], 1);
    chk("R1 rx ready low", rx_in_ready, 0);
    step(2'd2, 10'h0EE);
    chk("R8 push into full", rx_level, 15);
    for (int i = 0; i < 16; i++) begin
      chk("R7 drain order", rx_out_data, 8'h40 + i);
      step(2'd3, '0);
    end
    chk("R8 no stray byte", status_nib[2], 1);
    chk("R8 empty valid", rx_out_valid, 0);
    step(2'd3, '0);
    chk("R8 pop on empty", rx_level, 0);
    chk("R8 pop on empty flag", status_nib[2], 1);

    // threshold boundaries
    rx_thresh = 4'd0;
    @(negedge clk);
    chk("R4 thresh0 empty", irq_rx_level, 0);
    step(2'd2, 10'h055);
    chk("R4 thresh0 one entry", irq_rx_level, 1);
    chk("R2 one entry reads zero", rx_level, 0);
    rx_thresh = 4'd15;
    @(negedge clk);
    chk("R4 thresh15 one entry", irq_rx_level, 0);
    for (int i = 0; i < 14; i++) step(2'd2, 10'h066);
    chk("R4 thresh15 at 15", irq_rx_level, 0);
    step(2'd2, 10'h077);
    chk("R4 thresh15 at 16", irq_rx_level, 1);
    for (int i = 0; i < 16; i++) step(2'd3, '0);
    chk("R7 drained", status_nib[2], 1);

    // transmit half-empty
    for (int i = 0; i < 9; i++) step(2'd0, 10'(10'h300 + i));
    chk("R6 nine entries", irq_tx_half, 0);
    chk("R9 head entry", tx_out_data, 10'h300);
    step(2'd1, '0);
    chk("R6 eight entries", irq_tx_half, 1);
    chk("R2 tx level eight", tx_level, 7);

    // transmit flush
    tx_flush = 1;
    @(negedge clk);
    chk("R5 flush empty", status_nib[3], 1);
    chk("R5 flush level", tx_level, 0);
    chk("R5 flush ready", tx_in_ready, 0);
    step(2'd0, 10'h3FF);
    chk("R5 push during flush", status_nib[3], 1);
    tx_flush = 0;
    @(negedge clk);
    chk("R5 after release", status_nib[3], 1);
    chk("R5 no valid after", tx_out_valid, 0);
    step(2'd0, 10'h1AB);
    chk("R5 push after release", status_nib[3], 0);
    chk("R9 data after flush", tx_out_data, 10'h1AB);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule